// File: doc/BRIEF.md
# AUX Channel Transaction Controller

This block runs one request/reply exchange on a DisplayPort-style auxiliary channel under software control. Software fills a small data window of five 32-bit words with up to twenty request bytes, then writes a control word that carries a start bit, the request length, a bit-clock divider, an extra precharge length, a timeout choice and an interrupt enable. The controller waits out the sync period, hands the request bytes one at a time to a byte-level transmit port, and then collects the reply bytes from a byte-level receive port into the same data window.

Completion is reported in the control word. A busy bit stays set for the whole exchange. Done, timeout and receive-error flags are sticky and are cleared by writing ones to them. The reply length is written back into the length field. Line coding and the analog front end sit outside the block. A sink-present input lets a missing sink end the exchange at once instead of waiting out the timeout.

Top module: `auxch_ctrl`

## Requirements
- R1: Address 1 to 5 select data words 0 to 4. Request byte k sits in word k/4 at bits [31-8*(k%4) -: 8], so the most significant byte comes first. The request length is control bits 24:20, clamped to 20. Exactly that many bytes are offered on the transmit port, in index order. Each byte is held until it is accepted.
- R2: The n-th reply byte, counting from 0, is written to the position that request byte n would occupy. Reply bytes past the twentieth are dropped. Data bytes the reply does not reach keep their value.
- R3: Writing address 0 with bit 31 set while idle starts an exchange. Bit 31 reads 1 until the exchange ends. It then reads 0, and the done flag (bit 30) is set on the same edge.
- R4: Writing a 1 to bit 30, 28 or 26 of the control word clears done, timeout or receive-error respectively. Writing 0 to any of these bits leaves that flag unchanged.
- R5: On completion, bits 24:20 hold the number of reply bytes received. Reply counts of 0 or of more than 20 set the receive-error flag (bit 26).
- R6: The first request byte is offered exactly D*2*(10 + 2*E + 16) clock cycles after the edge that accepted the start write. D is bits 10:0, with 0 treated as 1. E is bits 19:16. One bit-clock tick lasts D cycles, and one microsecond is two ticks.
- R7: Once the request has been sent, if no reply byte arrives for the timeout period, done and timeout (bit 28) are set. The period is TO_SHORT_TICKS ticks when bit 27 is 0 and TO_LONG_TICKS ticks when bit 27 is 1.
- R8: A pulse on rx_err while waiting for the reply ends the exchange with done and receive-error set.
- R9: sink_ok low while busy ends the exchange on the next edge with done and timeout set.
- R10: Writes to the data words while busy have no effect.
- R11: irq pulses for one cycle when an exchange completes, if bit 29 is set. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 is control, 1 to 5 are data words |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| sink_ok | input | 1 | Sink present |
| tx_valid | output | 1 | Request byte offered |
| tx_data | output | 8 | Request byte |
| tx_ready | input | 1 | Link accepts the byte |
| rx_valid | input | 1 | Reply byte present |
| rx_data | input | 8 | Reply byte |
| rx_end | input | 1 | Reply finished (may coincide with a last byte) |
| rx_err | input | 1 | Reply corrupted |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The bench builds the controller with TO_SHORT_TICKS=40 and TO_LONG_TICKS=60, keeping the other parameters at their defaults. With these short reply windows, both timeout lengths can be measured against their cycle bounds within a few hundred cycles. Because the sync period keeps its default microsecond counts, the exact first-byte latency is checked for several divider and precharge values, including a divider of 0.

// File: rtl/auxch_pkg.sv
// Shared definitions for the AUX channel controller.
// Holds the control word field positions and the sequencer state encoding.
package auxch_pkg;
    localparam int AW           = 3;
    localparam int CTL_BUSY     = 31;
    localparam int CTL_DONE     = 30;
    localparam int CTL_IE       = 29;
    localparam int CTL_TO       = 28;
    localparam int CTL_TOSEL    = 27;
    localparam int CTL_RXE      = 26;
    localparam int SIZE_LO      = 20;
    localparam int SIZE_W       = 5;
    localparam int PRE_LO       = 16;
    localparam int PRE_W        = 4;
    localparam int DIV_W        = 11;
    localparam int TICKS_PER_US = 2;

    typedef enum logic [1:0] {S_IDLE, S_SYNC, S_SEND, S_WAIT} seq_state_t;
endpackage

// File: rtl/auxch_tick.sv
// Bit-clock tick generator.
// While en is high, tick pulses once every div cycles; a divider of 0 acts as 1.
// While en is low, the counter is held at zero, so the first tick comes div cycles after en rises.
module auxch_tick #(
    parameter int DIVW = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;
    logic [DIVW-1:0] eff_m1;

    // Last count value before wrap.
    always_comb eff_m1 = (div == '0) ? '0 : div - 1'b1;

    assign tick = en && (cnt == eff_m1);

    // Divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (tick)     cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/auxch_databuf.sv
// Data window of NWORDS 32-bit words, shared by the request and the reply.
// The bus writes whole words, and only while lock is low.
// The engine writes single bytes; byte index i maps to word i/4, with lane 0 in the top byte.
// Assumes that bus and engine never write in the same cycle, which holds because the engine writes only while locked.
module auxch_databuf #(
    parameter int NWORDS = 5,
    parameter int IW     = 5,
    localparam int NB    = 4 * NWORDS,
    localparam int WW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [WW-1:0] bus_word,
    input  logic [31:0]   bus_wdata,
    input  logic          lock,
    input  logic          eng_we,
    input  logic [IW-1:0] eng_idx,
    input  logic [7:0]    eng_byte,
    input  logic [WW-1:0] rd_word,
    output logic [31:0]   rd_data,
    input  logic [IW-1:0] tx_idx,
    output logic [7:0]    tx_byte
);
    logic [31:0]   mem [NWORDS];
    logic [WW-1:0] eng_w, tx_w;

    assign eng_w   = WW'(eng_idx >> 2);
    assign tx_w    = WW'(tx_idx >> 2);
    assign rd_data = mem[rd_word];
    assign tx_byte = mem[tx_w][{~tx_idx[1:0], 3'b000} +: 8];

    // Word storage: bus word writes and engine byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
        end else begin
            if (bus_we && !lock) mem[bus_word] <= bus_wdata;
            if (eng_we && (int'(eng_idx) < NB))
                mem[eng_w][{~eng_idx[1:0], 3'b000} +: 8] <= eng_byte;
        end
    end

    // R10
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && lock && !eng_we) |=> (mem[$past(bus_word)] == $past(mem[bus_word])));
endmodule

// File: rtl/auxch_seq.sv
// Exchange sequencer: sync wait, request send, reply collect, then finish.
// Assumes that tx_len, pre_ext and long_to stay constant while busy; the top blocks control writes while busy.
// fin pulses for one cycle, together with its cause flags and the final reply count.
module auxch_seq #(
    parameter int IW          = 5,
    parameter int NB          = 20,
    parameter int PRE_W       = 4,
    parameter int PRE_MIN_US  = 10,
    parameter int PREAMBLE_US = 16,
    parameter int TO_SHORT    = 800,
    parameter int TO_LONG     = 1200,
    localparam int SYNC_MAX   = auxch_pkg::TICKS_PER_US * (PRE_MIN_US + PREAMBLE_US + 2 * ((1 << PRE_W) - 1)),
    localparam int SYNCW      = $clog2(SYNC_MAX + 1),
    localparam int TOW        = $clog2(((TO_LONG > TO_SHORT) ? TO_LONG : TO_SHORT) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IW-1:0]    tx_len,
    input  logic [PRE_W-1:0] pre_ext,
    input  logic             long_to,
    input  logic             tick,
    input  logic             sink_ok,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic             rx_end,
    input  logic             rx_err,
    output logic             busy,
    output logic             tx_valid,
    output logic [IW-1:0]    tx_idx,
    output logic             rx_we,
    output logic [IW-1:0]    rx_idx,
    output logic             fin,
    output logic             fin_to,
    output logic             fin_rxe,
    output logic [IW-1:0]    rx_cnt_out
);
    import auxch_pkg::*;

    seq_state_t       state;
    logic [SYNCW-1:0] sync_cnt, sync_last;
    logic [TOW-1:0]   to_cnt, to_last;
    logic [IW-1:0]    rx_cnt, rx_inc;
    logic             abort, to_hit, wait_fin;

    assign busy       = (state != S_IDLE);
    assign tx_valid   = (state == S_SEND);
    assign rx_we      = (state == S_WAIT) && rx_valid;
    assign rx_idx     = rx_cnt;
    assign rx_cnt_out = rx_inc;

    // Window limits taken from the control fields.
    always_comb begin
        sync_last = SYNCW'(TICKS_PER_US * (PRE_MIN_US + PREAMBLE_US) - 1) + SYNCW'({pre_ext, 2'b00});
        to_last   = long_to ? TOW'(TO_LONG - 1) : TOW'(TO_SHORT - 1);
    end

    // Finish causes and the saturating reply count.
    always_comb begin
        rx_inc   = (rx_valid && (rx_cnt != '1)) ? rx_cnt + 1'b1 : rx_cnt;
        abort    = busy && !sink_ok;
        to_hit   = (state == S_WAIT) && !rx_valid && !rx_end && !rx_err && tick && (to_cnt == to_last);
        wait_fin = (state == S_WAIT) && (rx_err || rx_end || to_hit);
        fin      = abort || wait_fin;
        fin_to   = abort || to_hit;
        fin_rxe  = !abort && (state == S_WAIT) &&
                   (rx_err || (rx_end && ((rx_inc == '0) || (int'(rx_inc) > NB))));
    end

    // State and counter updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            sync_cnt <= '0;
            to_cnt   <= '0;
            tx_idx   <= '0;
            rx_cnt   <= '0;
        end else if (abort) begin
            state <= S_IDLE;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    state    <= S_SYNC;
                    sync_cnt <= '0;
                    tx_idx   <= '0;
                    rx_cnt   <= '0;
                end
                S_SYNC: if (tick) begin
                    if (sync_cnt == sync_last) begin
                        state  <= (tx_len != '0) ? S_SEND : S_WAIT;
                        to_cnt <= '0;
                    end else begin
                        sync_cnt <= sync_cnt + 1'b1;
                    end
                end
                S_SEND: if (tx_ready) begin
                    tx_idx <= tx_idx + 1'b1;
                    if (tx_idx == tx_len - 1'b1) begin
                        state  <= S_WAIT;
                        to_cnt <= '0;
                    end
                end
                default: begin
                    if (wait_fin) state <= S_IDLE;
                    rx_cnt <= rx_inc;
                    if (rx_valid)  to_cnt <= '0;
                    else if (tick) to_cnt <= to_cnt + 1'b1;
                end
            endcase
        end
    end

    // R1
    tx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_idx < tx_len));
    // R1
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && sink_ok) |=> (tx_valid && $stable(tx_idx)));
    // R9
    sink_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sink_ok) |=> !busy);
endmodule

// File: rtl/auxch_ctrl.sv
// AUX channel controller top: control/status register, data window, tick generator and sequencer.
// Control writes are ignored while busy. Done, timeout and receive-error are write-one-to-clear.
// The length field holds the request length until completion and the reply count after it.
module auxch_ctrl #(
    parameter int NWORDS         = 5,
    parameter int PRE_MIN_US     = 10,
    parameter int PREAMBLE_US    = 16,
    parameter int TO_SHORT_TICKS = 800,
    parameter int TO_LONG_TICKS  = 1200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        sink_ok,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_end,
    input  logic        rx_err,
    output logic        irq
);
    import auxch_pkg::*;

    localparam int NB = 4 * NWORDS;
    localparam int WW = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int IW = SIZE_W;

    logic              done_f, ie_f, to_f, tosel_f, rxe_f;
    logic [IW-1:0]     size_f, tx_len, tx_idx, rx_idx, rx_cnt;
    logic [PRE_W-1:0]  pre_f;
    logic [DIV_W-1:0]  div_f;
    logic              busy, tick, ctl_wr, start, data_sel;
    logic              fin, fin_to, fin_rxe, rx_we;
    logic [WW-1:0]     word_sel;
    logic [31:0]       word_rd;

    // Register decode.
    always_comb begin
        data_sel = (reg_addr != '0) && (int'(reg_addr) <= NWORDS);
        word_sel = data_sel ? WW'(reg_addr - 3'd1) : '0;
        ctl_wr   = reg_we && (reg_addr == '0) && !busy;
        start    = ctl_wr && reg_wdata[CTL_BUSY];
        tx_len   = (int'(size_f) > NB) ? IW'(NB) : size_f;
    end

    // Read mux.
    always_comb begin
        if (reg_addr == '0) begin
            reg_rdata = '0;
            reg_rdata[CTL_BUSY]  = busy;
            reg_rdata[CTL_DONE]  = done_f;
            reg_rdata[CTL_IE]    = ie_f;
            reg_rdata[CTL_TO]    = to_f;
            reg_rdata[CTL_TOSEL] = tosel_f;
            reg_rdata[CTL_RXE]   = rxe_f;
            reg_rdata[SIZE_LO +: SIZE_W] = size_f;
            reg_rdata[PRE_LO +: PRE_W]   = pre_f;
            reg_rdata[DIV_W-1:0]         = div_f;
        end else begin
            reg_rdata = data_sel ? word_rd : '0;
        end
    end

    // Control/status register and completion capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_f <= 1'b0; ie_f <= 1'b0; to_f <= 1'b0; tosel_f <= 1'b0; rxe_f <= 1'b0;
            size_f <= '0; pre_f <= '0; div_f <= '0; irq <= 1'b0;
        end else begin
            irq <= fin && ie_f;
            if (fin) begin
                done_f <= 1'b1;
                to_f   <= to_f | fin_to;
                rxe_f  <= rxe_f | fin_rxe;
                size_f <= rx_cnt;
            end else if (ctl_wr) begin
                ie_f    <= reg_wdata[CTL_IE];
                tosel_f <= reg_wdata[CTL_TOSEL];
                size_f  <= reg_wdata[SIZE_LO +: SIZE_W];
                pre_f   <= reg_wdata[PRE_LO +: PRE_W];
                div_f   <= reg_wdata[DIV_W-1:0];
                done_f  <= done_f & ~reg_wdata[CTL_DONE];
                to_f    <= to_f & ~reg_wdata[CTL_TO];
                rxe_f   <= rxe_f & ~reg_wdata[CTL_RXE];
            end
        end
    end

    auxch_tick #(.DIVW(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .en(busy), .div(div_f), .tick(tick)
    );

    auxch_databuf #(.NWORDS(NWORDS), .IW(IW)) buf_i (
        .clk(clk), .rst_n(rst_n),
        .bus_we(reg_we && data_sel), .bus_word(word_sel), .bus_wdata(reg_wdata), .lock(busy),
        .eng_we(rx_we), .eng_idx(rx_idx), .eng_byte(rx_data),
        .rd_word(word_sel), .rd_data(word_rd),
        .tx_idx(tx_idx), .tx_byte(tx_data)
    );

    auxch_seq #(
        .IW(IW), .NB(NB), .PRE_W(PRE_W), .PRE_MIN_US(PRE_MIN_US), .PREAMBLE_US(PREAMBLE_US),
        .TO_SHORT(TO_SHORT_TICKS), .TO_LONG(TO_LONG_TICKS)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_len(tx_len), .pre_ext(pre_f),
        .long_to(tosel_f), .tick(tick), .sink_ok(sink_ok), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_end(rx_end), .rx_err(rx_err),
        .busy(busy), .tx_valid(tx_valid), .tx_idx(tx_idx), .rx_we(rx_we), .rx_idx(rx_idx),
        .fin(fin), .fin_to(fin_to), .fin_rxe(fin_rxe), .rx_cnt_out(rx_cnt)
    );

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_f) |-> !busy);
    // R7
    to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_f) |-> done_f);
    // R5
    rxe_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxe_f) |-> done_f);
    // R11
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_f && ie_f));
endmodule

// File: tb/auxch_ctrl_tb_top.sv
`timescale 1ns/1ps
module auxch_ctrl_tb_top;
    localparam int NB  = 20;
    localparam int TOS = 40;
    localparam int TOL = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sink_ok = 1'b1;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_end = 1'b0;
    logic        rx_err = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    int irq_cnt = 0;
    bit finished = 0;
    logic [7:0] exp_buf [NB];

    always #2.5 clk = ~clk;

    auxch_ctrl #(.TO_SHORT_TICKS(TOS), .TO_LONG_TICKS(TOL)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sink_ok(sink_ok), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
        .rx_err(rx_err), .irq(irq)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int w);
        return {exp_buf[4*w], exp_buf[4*w+1], exp_buf[4*w+2], exp_buf[4*w+3]};
    endfunction

    function automatic int sync_cycles(input int d, input int e);
        return 2 * (10 + 2 * e + 16) * ((d == 0) ? 1 : d);
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    // mode: 0 normal reply, 1 no reply, 2 receive error, 3 sink lost
    task automatic run(input int len, input int dv, input int ext, input int tosel,
                       input int ie, input int mode, input int rlen);
        logic [31:0] v, ctl;
        int m, sent, lenc, effd, lim, n, exp_size;
        bit exp_to, exp_re;
        for (int w = 0; w < 5; w++) begin
            v = $urandom;
            wr(3'(w + 1), v);
            for (int b = 0; b < 4; b++) exp_buf[4*w+b] = v[31-8*b -: 8];
        end
        irq_cnt = 0;
        ctl = (32'(ie) << 29) | (32'(tosel) << 27) | (32'(len) << 20) | (32'(ext) << 16) | 32'(dv);
        wr(3'd0, ctl | 32'h8000_0000);
        effd = (dv == 0) ? 1 : dv;
        lenc = (len > NB) ? NB : len;
        if (lenc > 0) begin
            m = 0;
            while (!tx_valid && m < 5000) begin @(negedge clk); m++; end
            chk("R6 first byte latency", m, sync_cycles(dv, ext));
            wr(3'd5, $urandom);
            rd(3'd0, v);
            chk("R10 still busy around locked write", {31'd0, v[31]}, 1);
        end else begin
            repeat (sync_cycles(dv, ext)) @(negedge clk);
        end
        if (mode == 3) begin
            sink_ok = 1'b0;
            @(negedge clk);
            rd(3'd0, v);
            chk("R9 busy drops after sink loss", {31'd0, v[31]}, 0);
            sink_ok = 1'b1;
        end else begin
            sent = 0; n = 0;
            while (sent < lenc && n < 2000) begin
                tx_ready = ($urandom % 3) != 0;
                #0.5;
                if (tx_valid && tx_ready) begin
                    chk("R1 request byte", tx_data, exp_buf[sent]);
                    sent++;
                end
                @(negedge clk);
                n++;
            end
            tx_ready = 1'b0;
            chk("R1 no extra request byte", {31'd0, tx_valid}, 0);
            if (mode == 0) begin
                for (int i = 0; i < rlen; i++) begin
                    rx_valid = 1'b1; rx_data = 8'($urandom);
                    if (i < NB) exp_buf[i] = rx_data;
                    @(negedge clk);
                end
                rx_valid = 1'b0; rx_end = 1'b1;
                @(negedge clk);
                rx_end = 1'b0;
            end else if (mode == 2) begin
                for (int i = 0; i < 2; i++) begin
                    rx_valid = 1'b1; rx_data = 8'($urandom);
                    exp_buf[i] = rx_data;
                    @(negedge clk);
                end
                rx_valid = 1'b0; rx_err = 1'b1;
                @(negedge clk);
                rx_err = 1'b0;
            end else begin
                lim = tosel ? TOL : TOS;
                n = 0;
                rd(3'd0, v);
                while (v[31] && n < 20000) begin @(negedge clk); n++; rd(3'd0, v); end
                chk("R7 timeout window", {31'd0, (n >= (lim - 1) * effd + 1) && (n <= lim * effd)}, 1);
            end
        end
        n = 0;
        rd(3'd0, v);
        while (v[31] && n < 20000) begin @(negedge clk); n++; rd(3'd0, v); end
        @(negedge clk);
        rd(3'd0, v);
        exp_to   = (mode == 1) || (mode == 3);
        exp_re   = (mode == 2) || ((mode == 0) && ((rlen == 0) || (rlen > NB)));
        exp_size = (mode == 0) ? ((rlen > 31) ? 31 : rlen) : ((mode == 2) ? 2 : 0);
        chk("R3 idle with done", {30'd0, v[31], v[30]}, 32'd1);
        chk("R7 R9 timeout flag", {31'd0, v[28]}, 32'(exp_to));
        chk("R5 R8 receive-error flag", {31'd0, v[26]}, 32'(exp_re));
        if (mode != 3) chk("R5 reply size", {27'd0, v[24:20]}, exp_size);
        chk("R11 irq pulses", irq_cnt, ie);
        for (int w = 0; w < 5; w++) begin
            rd(3'(w + 1), v);
            chk("R2 R10 data word", v, exp_word(w));
        end
        wr(3'd0, ctl | 32'h4000_0000);
        rd(3'd0, v);
        chk("R4 done cleared, others kept", {29'd0, v[30], v[28], v[26]}, {29'd0, 1'b0, exp_to, exp_re});
        wr(3'd0, ctl | 32'h1400_0000);
        rd(3'd0, v);
        chk("R4 error flags cleared", {29'd0, v[30], v[28], v[26]}, 0);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd0, v);
        chk("R3 reset control word", v, 0);
        rd(3'd1, v);
        chk("R2 reset data word", v, 0);
        chk("R11 reset irq", {31'd0, irq}, 0);
        chk("R1 reset tx idle", {31'd0, tx_valid}, 0);
        run(4, 1, 0, 0, 1, 0, 4);
        run(25, 0, 1, 0, 0, 0, 22);
        run(0, 2, 0, 0, 1, 0, 0);
        run(3, 2, 0, 0, 1, 1, 0);
        run(3, 2, 2, 1, 0, 1, 0);
        run(5, 1, 2, 0, 1, 2, 0);
        run(6, 3, 1, 0, 1, 3, 0);
        for (int k = 0; k < 8; k++)
            run(1 + $urandom % 20, 1 + $urandom % 3, $urandom % 4, 0,
                $urandom % 2, 0, 1 + $urandom % 20);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule